// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Front-End

This block sits between a register port and the bit-level engine of an I2C master. Software issues all traffic through one data/command address. A write there queues a transmit command: bit 8 selects a read request, and otherwise bits 7:0 are a byte to send. A read of the same address takes the oldest received byte out of the receive queue. Software can also read the live fill level of each queue and a fixed parameter word that holds both queue depths.

On the bus side, the bit engine takes commands through a valid/ready handshake and returns received bytes with a single valid strobe. A read request is only accepted while a receive slot is free for the byte it will bring back. The slot is counted from the moment the request is queued until a byte arrives. The block keeps three sticky error flags. Writing a zero to the enable register empties both queues, drops all outstanding read credit and clears the flags.

Register offsets on `reg_addr`: 0 data/command, 1 enable, 2 transmit level, 3 receive level, 4 parameter word. Any other offset reads as zero. A register read returns its value in `reg_rdata` on the clock edge that samples `reg_rd`, and the value holds until the next read.

Top module: `i2cq_frontend`

## Requirements
- R1: After reset, both levels read 0, `cmd_valid`, `engine_en` and all three flags are 0.
- R2: A read of offset 4 returns transmit depth minus one in bits 23:16 and receive depth minus one in bits 15:8, with all other bits 0.
- R3: A write to offset 0 with bit 8 clear queues a command with `cmd_rd`=0 and `cmd_byte` equal to bits 7:0. The transmit level (offset 2) counts it from the edge of the write.
- R4: A write to offset 0 with bit 8 set queues a command with `cmd_rd`=1.
- R5: While the transmit queue is not empty, `cmd_valid` is 1 and presents the oldest command. Each edge with `cmd_valid` and `cmd_ready` both high removes that command, so commands leave in write order.
- R6: A write to offset 0 while the transmit queue is full and no command leaves in the same cycle is dropped. The level and contents stay unchanged, and `tx_overflow` is set.
- R7: A read-request write is dropped, with `tx_overflow` set, when the receive level plus the outstanding read requests already equals the receive depth. An outstanding request is released by each `rx_valid` strobe.
- R8: A read of offset 0 returns the oldest received byte in bits 7:0 and removes it. Offset 3 reports the number of bytes held.
- R9: A read of offset 0 with the receive queue empty returns 0, leaves the level at 0 and sets `rx_underflow`.
- R10: An `rx_valid` strobe while the receive queue is full and no byte leaves in the same cycle is dropped, keeping the stored bytes, and sets `rx_overflow`.
- R11: A receive push and a receive pop in the same cycle leave the receive level unchanged and keep byte order.
- R12: A write to offset 1 drives `engine_en` from bit 0. When bit 0 is 0, both levels, `cmd_valid`, the outstanding read credit and all three flags return to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| engine_en | output | 1 | Enable bit for the bit engine |
| cmd_valid | output | 1 | A command is available |
| cmd_ready | input | 1 | Bit engine takes the command |
| cmd_rd | output | 1 | Command is a read request |
| cmd_byte | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_overflow | output | 1 | Sticky: command write dropped |
| rx_underflow | output | 1 | Sticky: data read while empty |
| rx_overflow | output | 1 | Sticky: received byte dropped |

## Verification
Every result is due on the first clock edge after its stimulus. Queue levels, flags, `cmd_valid`, the presented command and `reg_rdata` all change on the edge that samples the write, read, pop or push, with no further stage. The bench therefore drives each access on a falling edge, lets one rising edge pass, and checks the outputs on the next falling edge. Same-cycle cases are built by raising two strobes before the same rising edge: a receive push with a data read, and a full-queue write. The results are then read back through the level registers.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA   = 3'd0,
        RA_ENABLE = 3'd1,
        RA_TXLVL  = 3'd2,
        RA_RXLVL  = 3'd3,
        RA_PARAM  = 3'd4
    } i2cq_addr_e;

    // one queued command: read request marker plus byte to send
    typedef struct packed {
        logic       rd_req;
        logic [7:0] wbyte;
    } i2cq_cmd_t;

    typedef struct packed {
        logic tx_ovf;
        logic rx_unf;
        logic rx_ovf;
    } i2cq_flags_t;

    function automatic logic [31:0] depth_word(input int tx_d, input int rx_d);
        logic [7:0] t;
        logic [7:0] r;
        t = 8'(tx_d - 1);
        r = 8'(rx_d - 1);
        return {8'h00, t, r, 8'h00};
    endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          push_drop,
    output logic          pop_drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign do_pop    = pop && !empty;
    assign do_push   = push && (!full || do_pop);
    assign push_drop = push && !do_push;
    assign pop_drop  = pop && empty;
    assign rdata     = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2cq_credit.sv
module i2cq_credit #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int SW   = CW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          take,
    input  logic          give,
    input  logic [CW-1:0] level,
    output logic          slot_free
);
    logic [CW-1:0] pending;
    logic [SW-1:0] used;
    logic          rel;

    assign used      = {1'b0, level} + {1'b0, pending};
    assign slot_free = used < SW'(DEPTH);
    assign rel       = give && (pending != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pending <= '0;
        end else begin
            case ({take, rel})
                2'b10:   pending <= pending + 1'b1;
                2'b01:   pending <= pending - 1'b1;
                default: pending <= pending;
            endcase
        end
    end
endmodule

// File: rtl/i2cq_flags.sv
module i2cq_flags
    import i2cq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  i2cq_flags_t set,
    output i2cq_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst || clr) flags <= '0;
        else            flags <= flags | set;
    end
endmodule

// File: rtl/i2cq_frontend.sv
module i2cq_frontend
    import i2cq_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              engine_en,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_rd,
    output logic [7:0]        cmd_byte,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              tx_overflow,
    output logic              rx_underflow,
    output logic              rx_overflow
);
    localparam int TCW = $clog2(TX_DEPTH + 1);
    localparam int RCW = $clog2(RX_DEPTH + 1);
    localparam logic [31:0] DEPTHS = depth_word(TX_DEPTH, RX_DEPTH);

    i2cq_cmd_t   wcmd, head;
    i2cq_flags_t flag_set, flag_q;
    logic [TCW-1:0] tx_count;
    logic [RCW-1:0] rx_count;
    logic [7:0]     rx_head;
    logic wr_data, rd_data, flush;
    logic tx_push, tx_empty, tx_full, tx_drop, tx_unused_unf;
    logic rx_empty, rx_full, rx_drop, rx_unf;
    logic slot_free, credit_drop, credit_take;

    assign wcmd    = i2cq_cmd_t'(reg_wdata[8:0]);
    assign wr_data = reg_wr && (reg_addr == RA_DATA);
    assign rd_data = reg_rd && (reg_addr == RA_DATA);
    assign flush   = reg_wr && (reg_addr == RA_ENABLE) && !reg_wdata[0];

    // read requests need a free receive slot for their returning byte
    assign credit_drop = wr_data && wcmd.rd_req && !slot_free;
    assign tx_push     = wr_data && !credit_drop;
    assign credit_take = tx_push && wcmd.rd_req && !tx_drop;

    i2cq_fifo #(.W($bits(i2cq_cmd_t)), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(tx_push), .wdata(wcmd),
        .pop(cmd_ready), .rdata(head),
        .count(tx_count), .empty(tx_empty), .full(tx_full),
        .push_drop(tx_drop), .pop_drop(tx_unused_unf)
    );

    i2cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(rx_valid), .wdata(rx_byte),
        .pop(rd_data), .rdata(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full),
        .push_drop(rx_drop), .pop_drop(rx_unf)
    );

    i2cq_credit #(.DEPTH(RX_DEPTH)) u_credit (
        .clk(clk), .rst(rst), .flush(flush),
        .take(credit_take), .give(rx_valid),
        .level(rx_count), .slot_free(slot_free)
    );

    assign flag_set.tx_ovf = tx_drop || credit_drop;
    assign flag_set.rx_unf = rx_unf;
    assign flag_set.rx_ovf = rx_drop;

    i2cq_flags u_flags (
        .clk(clk), .rst(rst), .clr(flush),
        .set(flag_set), .flags(flag_q)
    );

    assign tx_overflow  = flag_q.tx_ovf;
    assign rx_underflow = flag_q.rx_unf;
    assign rx_overflow  = flag_q.rx_ovf;
    assign cmd_valid    = !tx_empty;
    assign cmd_rd       = head.rd_req;
    assign cmd_byte     = head.wbyte;

    always_ff @(posedge clk) begin
        if (rst) begin
            engine_en <= 1'b0;
        end else if (reg_wr && (reg_addr == RA_ENABLE)) begin
            engine_en <= reg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                RA_DATA:   reg_rdata <= rx_empty ? 32'h0 : {24'h0, rx_head};
                RA_ENABLE: reg_rdata <= {31'h0, engine_en};
                RA_TXLVL:  reg_rdata <= 32'(tx_count);
                RA_RXLVL:  reg_rdata <= 32'(rx_count);
                RA_PARAM:  reg_rdata <= DEPTHS;
                default:   reg_rdata <= 32'h0;
            endcase
        end
    end
endmodule

// File: rtl/i2cq_checker.sv
module i2cq_checker #(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TCW = $clog2(TX_DEPTH + 1),
    localparam int RCW = $clog2(RX_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           reg_wr,
    input logic           reg_rd,
    input logic [2:0]     reg_addr,
    input logic [31:0]    reg_wdata,
    input logic [31:0]    reg_rdata,
    input logic           cmd_valid,
    input logic           cmd_ready,
    input logic           rx_valid,
    input logic           tx_overflow,
    input logic           rx_underflow,
    input logic           rx_overflow,
    input logic [TCW-1:0] tx_lvl,
    input logic [RCW-1:0] rx_lvl
);
    logic [31:0] exp_param;
    assign exp_param = ((TX_DEPTH - 1) << 16) | ((RX_DEPTH - 1) << 8);

    logic data_rd, data_wr, flush_wr;
    assign data_rd  = reg_rd && reg_addr == 3'd0;
    assign data_wr  = reg_wr && reg_addr == 3'd0;
    assign flush_wr = reg_wr && reg_addr == 3'd1 && !reg_wdata[0];

    p_param_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd4) |=> reg_rdata == exp_param);

    p_tx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        tx_lvl <= TCW'(TX_DEPTH));

    p_tx_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (data_wr && tx_lvl == TCW'(TX_DEPTH) && !cmd_ready)
        |=> tx_overflow && tx_lvl == TCW'(TX_DEPTH));

    p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
        (data_rd && rx_lvl == '0 && !rx_valid)
        |=> reg_rdata == 32'h0 && rx_underflow && rx_lvl == '0);

    p_rx_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_lvl == RCW'(RX_DEPTH) && !data_rd && !flush_wr)
        |=> rx_overflow && rx_lvl == RCW'(RX_DEPTH));

    p_same_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && data_rd && rx_lvl != '0 && !flush_wr)
        |=> rx_lvl == $past(rx_lvl));

    p_flush_r12: assert property (@(posedge clk) disable iff (rst)
        flush_wr |=> tx_lvl == '0 && rx_lvl == '0 && !cmd_valid
                     && !tx_overflow && !rx_underflow && !rx_overflow);
endmodule

bind i2cq_frontend i2cq_checker #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .rx_valid(rx_valid),
    .tx_overflow(tx_overflow), .rx_underflow(rx_underflow),
    .rx_overflow(rx_overflow), .tx_lvl(tx_count), .rx_lvl(rx_count)
);

// File: tb/sim_i2cq_frontend.sv
module sim_i2cq_frontend;
    localparam int TXD = 4;
    localparam int RXD = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        engine_en, cmd_valid, cmd_rd;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_overflow, rx_underflow, rx_overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2cq_frontend #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .engine_en(engine_en), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_rd(cmd_rd), .cmd_byte(cmd_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_overflow(tx_overflow),
        .rx_underflow(rx_underflow), .rx_overflow(rx_overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // access driven on a falling edge, result visible on the next falling edge
    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop_cmd(input string req, input logic r, input logic [7:0] b);
        chk(req, {31'h0, cmd_valid}, 32'h1);
        chk(req, {23'h0, cmd_rd, cmd_byte}, {23'h0, r, b});
        cmd_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic restart();
        reg_write(3'd1, 32'h0);
        reg_write(3'd1, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 cmd_valid", {31'h0, cmd_valid}, 32'h0);
        chk("R1 engine_en", {31'h0, engine_en}, 32'h0);
        chk("R1 flags", {29'h0, tx_overflow, rx_underflow, rx_overflow}, 32'h0);
        reg_read(3'd2, v); chk("R1 tx level", v, 32'h0);
        reg_read(3'd3, v); chk("R1 rx level", v, 32'h0);
    endtask

    task automatic t_param();
        logic [31:0] v;
        reg_read(3'd4, v);
        chk("R2 param word", v, 32'h0003_0500);
    endtask

    task automatic t_write_and_pop();
        logic [31:0] v;
        restart();
        chk("R12 engine_en set", {31'h0, engine_en}, 32'h1);
        reg_write(3'd0, 32'h0000_00A5);
        reg_write(3'd0, 32'h0000_01C3);
        reg_read(3'd2, v); chk("R3 tx level", v, 32'd2);
        pop_cmd("R3 write byte", 1'b0, 8'hA5);
        pop_cmd("R4 read request", 1'b1, 8'hC3);
        chk("R5 queue drained", {31'h0, cmd_valid}, 32'h0);
        reg_read(3'd2, v); chk("R5 tx level after pops", v, 32'd0);
    endtask

    task automatic t_tx_overflow();
        logic [31:0] v;
        restart();
        for (int i = 0; i < TXD + 1; i++) reg_write(3'd0, 32'h11 * (i + 1));
        chk("R6 tx_overflow", {31'h0, tx_overflow}, 32'h1);
        reg_read(3'd2, v); chk("R6 tx level full", v, TXD);
        for (int i = 0; i < TXD; i++) pop_cmd("R6 kept order", 1'b0, 8'(8'h11 * (i + 1)));
        chk("R6 dropped entry absent", {31'h0, cmd_valid}, 32'h0);
    endtask

    task automatic t_credit();
        logic [31:0] v;
        restart();
        for (int i = 0; i < TXD; i++) reg_write(3'd0, 32'h100 | i);
        cmd_ready = 1'b1;
        repeat (TXD) @(posedge clk);
        @(negedge clk); cmd_ready = 1'b0;
        reg_write(3'd0, 32'h104);
        reg_write(3'd0, 32'h105);
        chk("R7 no drop with credit", {31'h0, tx_overflow}, 32'h0);
        reg_write(3'd0, 32'h106);
        chk("R7 drop without credit", {31'h0, tx_overflow}, 32'h1);
        reg_read(3'd2, v); chk("R7 tx level after drop", v, 32'd2);
        push_rx(8'h5A);
        reg_write(3'd0, 32'h107);
        reg_read(3'd2, v); chk("R7 still no slot", v, 32'd2);
        reg_read(3'd0, v); chk("R7 returned byte", v, 32'h5A);
        reg_write(3'd0, 32'h108);
        reg_read(3'd2, v); chk("R7 slot freed", v, 32'd3);
    endtask

    task automatic t_rx_order();
        logic [31:0] v;
        restart();
        push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
        reg_read(3'd3, v); chk("R8 rx level", v, 32'd3);
        reg_read(3'd0, v); chk("R8 first byte", v, 32'h11);
        reg_read(3'd0, v); chk("R8 second byte", v, 32'h22);
        reg_read(3'd0, v); chk("R8 third byte", v, 32'h33);
        reg_read(3'd3, v); chk("R8 rx level drained", v, 32'd0);
    endtask

    task automatic t_empty_read();
        logic [31:0] v;
        restart();
        reg_read(3'd0, v); chk("R9 empty read value", v, 32'h0);
        chk("R9 rx_underflow", {31'h0, rx_underflow}, 32'h1);
        reg_read(3'd3, v); chk("R9 rx level", v, 32'd0);
    endtask

    task automatic t_rx_overflow();
        logic [31:0] v;
        restart();
        for (int i = 0; i < RXD + 1; i++) push_rx(8'(8'h40 + i));
        chk("R10 rx_overflow", {31'h0, rx_overflow}, 32'h1);
        reg_read(3'd3, v); chk("R10 rx level full", v, RXD);
        for (int i = 0; i < RXD; i++) begin
            reg_read(3'd0, v); chk("R10 stored byte", v, 32'h40 + i);
        end
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        restart();
        push_rx(8'h71); push_rx(8'h72);
        rx_valid = 1'b1; rx_byte = 8'h73;
        reg_rd = 1'b1; reg_addr = 3'd0;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0; reg_rd = 1'b0;
        chk("R11 popped byte", reg_rdata, 32'h71);
        reg_read(3'd3, v); chk("R11 level unchanged", v, 32'd2);
        reg_read(3'd0, v); chk("R11 order 2", v, 32'h72);
        reg_read(3'd0, v); chk("R11 order 3", v, 32'h73);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        restart();
        reg_write(3'd0, 32'h0EE);
        push_rx(8'h99);
        reg_read(3'd0, v); reg_read(3'd0, v);
        chk("R12 flag before", {31'h0, rx_underflow}, 32'h1);
        reg_write(3'd1, 32'h0);
        chk("R12 engine_en clear", {31'h0, engine_en}, 32'h0);
        chk("R12 cmd_valid", {31'h0, cmd_valid}, 32'h0);
        chk("R12 flags", {29'h0, tx_overflow, rx_underflow, rx_overflow}, 32'h0);
        reg_read(3'd2, v); chk("R12 tx level", v, 32'd0);
        reg_read(3'd3, v); chk("R12 rx level", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_param();
        t_write_and_pop();
        t_tx_overflow();
        t_credit();
        t_rx_order();
        t_empty_read();
        t_rx_overflow();
        t_same_cycle();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule